// File: doc/BRIEF.md
# Streaming Test Sequence Checker

This block watches a data stream that carries at most one word per clock, qualified by a valid strobe. It decides whether the words follow a known test pattern. The pattern is either a pseudo-random shift-register sequence or a counter. In counter mode the allowed increment is +1, or, when step mode is built in, any one of several signed step values. The expectation is rebuilt from every received word. A checker can therefore be switched on in the middle of a running stream: the first word seeds it, and every later word is compared with the value predicted from the word before it.

Wide buses often carry several replicated copies of a narrower pattern. For these, a front stage folds the input word down to the pattern width. If any upper copy disagrees with the low copy, the folded word becomes all ones, which the checker then flags as a pattern break. A three-state machine tracks whether a seed word is held and whether checking has started. Alongside it, the block keeps a sticky error flag, a count of received words and the last word received.

States of the machine:
- `S_IDLE` holds no word.
- `S_SEEDED` holds one word.
- `S_CHECKING` means at least one word has been checked.

Transitions:
- `S_IDLE` moves to `S_SEEDED` on a valid word.
- `S_SEEDED` moves to `S_CHECKING` on a valid word.
- `S_CHECKING` stays where it is.
- Every state returns to `S_IDLE` while enable is low.

Top module: `seq_stream_checker`

## Requirements
- R1: While `enable` is low (as seen after the input latency of R11), `seq_err`, `res_valid`, `rx_count` and `rx_sample` are all zero and the machine returns to `S_IDLE`.
- R2: With `mode_sel`=0 a word is correct when it equals `{prev[W-2:0], ^(prev & TAPS)}`, where prev is the previous valid word and W is SEQ_W. TAPS is 8'hB8 at 8 bits, 16'hB400 at 16 bits and 32'h8020_0003 at 32 bits.
- R3: With `mode_sel`=1 and USE_STEPS=1, a word is correct when it equals prev plus any one of the NUM_STEPS signed steps, modulo 2^SEQ_W. Step i occupies `step_vec[i*SEQ_W +: SEQ_W]`.
- R4: With `mode_sel`=1 and USE_STEPS=0, a word is correct only when it equals prev+1 modulo 2^SEQ_W, so a rollover from all ones to zero is accepted. `step_vec` has no effect in this configuration.
- R5: `res_valid` rises only once two valid words have arrived since enable. The first word only seeds the expectation.
- R6: `seq_err` sets when a checked word is wrong and stays set until enable goes low.
- R7: `rx_count` increases by one for every valid word received while enabled.
- R8: `rx_sample` holds the last valid word after folding.
- R9: Cycles with `in_valid` low change none of the outputs.
- R10: When DATA_W > SEQ_W, input bit i (i >= SEQ_W) is compared with bit i mod SEQ_W. Any mismatch replaces the word with all ones.
- R11: Outputs reflect an input, including `enable` and `mode_sel`, two rising edges after it is presented when DATA_W > SEQ_W, and one edge after when DATA_W = SEQ_W. A change of `mode_sel` while enabled applies from the next checked word and leaves `seq_err` as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables checking; low clears all state |
| mode_sel | input | 1 | 0 = pseudo-random pattern, 1 = counter pattern |
| step_vec | input | NUM_STEPS*SEQ_W | Signed counter steps, step i at bits i*SEQ_W upward |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Input word, possibly replicated copies |
| seq_err | output | 1 | Sticky pattern error |
| res_valid | output | 1 | Result is meaningful (two words seen) |
| rx_count | output | CNT_W | Valid words received since enable |
| rx_sample | output | SEQ_W | Last valid word after folding |

## Verification
The bench builds two instances from the same stimulus. The first uses SEQ_W=8, DATA_W=16 and USE_STEPS=1. It exercises the registered folding stage, forced all-ones words and four signed steps including a negative one, and it reaches the 8-bit counter rollover within a few words. The second uses SEQ_W=DATA_W=8 and USE_STEPS=0, with no folding register and +1 as the only increment. The same counter stream with steps of +3 and -2 therefore passes on the first instance and fails on the second. A scoreboard predicts every output cycle for both latencies.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_SEEDED   = 2'd1,
        S_CHECKING = 2'd2
    } chk_state_e;

    // Feedback mask for a left-shifting pseudo-random sequence of width w
    function automatic logic [63:0] lfsr_taps(input int unsigned w);
        logic [63:0] m;
        case (w)
            8:       m = 64'h0000_0000_0000_00B8;
            16:      m = 64'h0000_0000_0000_B400;
            32:      m = 64'h0000_0000_8020_0003;
            default: m = (64'd1 << (w - 1)) | 64'd1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/seqchk_fold.sv
module seqchk_fold #(
    parameter int DATA_W = 64,
    parameter int SEQ_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sel_i,
    input  logic              val_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              en_o,
    output logic              sel_o,
    output logic              val_o,
    output logic [SEQ_W-1:0]  dat_o
);

    generate
        if (DATA_W == SEQ_W) begin : g_pass
            assign en_o  = en_i;
            assign sel_o = sel_i;
            assign val_o = val_i;
            assign dat_o = data_i;
        end else begin : g_fold
            localparam int UP_W = DATA_W - SEQ_W;
            logic [UP_W-1:0]  diff;
            logic             bad;
            logic             en_q, sel_q, val_q;
            logic [SEQ_W-1:0] dat_q;

            for (genvar b = 0; b < UP_W; b++) begin : g_cmp
                assign diff[b] = data_i[SEQ_W + b] ^ data_i[(SEQ_W + b) % SEQ_W];
            end
            assign bad = |diff;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q  <= 1'b0;
                    sel_q <= 1'b0;
                    val_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    en_q  <= en_i;
                    sel_q <= sel_i;
                    val_q <= val_i;
                    dat_q <= bad ? {SEQ_W{1'b1}} : data_i[SEQ_W-1:0];
                end
            end

            assign en_o  = en_q;
            assign sel_o = sel_q;
            assign val_o = val_q;
            assign dat_o = dat_q;

            // R10: a disagreeing upper copy yields an all-ones word one edge later
            a_r10_force_ones: assert property (@(posedge clk) disable iff (!rst_n)
                (val_i && (data_i[DATA_W-1:SEQ_W] != {UP_W{1'b0}}) && bad) |=> (val_o && dat_o == {SEQ_W{1'b1}}));
            // R11: the control inputs travel with the data
            a_r11_en_aligned: assert property (@(posedge clk) disable iff (!rst_n)
                en_i |=> en_o);
        end
    endgenerate

endmodule

// File: rtl/seqchk_core.sv
module seqchk_core
    import seqchk_pkg::*;
#(
    parameter int SEQ_W     = 32,
    parameter int NUM_STEPS = 4,
    parameter int CNT_W     = 32,
    parameter bit USE_STEPS = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       sel_i,
    input  logic [NUM_STEPS*SEQ_W-1:0] step_vec_i,
    input  logic                       val_i,
    input  logic [SEQ_W-1:0]           dat_i,
    output logic                       err_o,
    output logic                       res_val_o,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [SEQ_W-1:0]           smp_o
);

    localparam logic [63:0]      TAPS_ALL = lfsr_taps(SEQ_W);
    localparam logic [SEQ_W-1:0] TAPS     = TAPS_ALL[SEQ_W-1:0];
    localparam logic [SEQ_W-1:0] ONE      = {{(SEQ_W-1){1'b0}}, 1'b1};

    chk_state_e       state_q, state_d;
    logic [SEQ_W-1:0] prev_q, smp_q, lfsr_exp;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q, cnt_ok, lfsr_ok, word_ok;

    // Expected pseudo-random successor of the previous received word
    assign lfsr_exp = {prev_q[SEQ_W-2:0], ^(prev_q & TAPS)};
    assign lfsr_ok  = (dat_i == lfsr_exp);

    generate
        if (USE_STEPS) begin : g_steps
            logic [NUM_STEPS-1:0] step_hit;
            for (genvar g = 0; g < NUM_STEPS; g++) begin : g_hit
                assign step_hit[g] = (dat_i == prev_q + step_vec_i[g*SEQ_W +: SEQ_W]);
            end
            assign cnt_ok = |step_hit;
        end else begin : g_unit
            assign cnt_ok = (dat_i == prev_q + ONE);
        end
    endgenerate

    assign word_ok = sel_i ? cnt_ok : lfsr_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     if (val_i) state_d = S_SEEDED;
                S_SEEDED:   if (val_i) state_d = S_CHECKING;
                S_CHECKING: state_d = S_CHECKING;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            cnt_q  <= '0;
            smp_q  <= '0;
            prev_q <= '0;
        end else if (!en_i) begin
            err_q  <= 1'b0;
            cnt_q  <= '0;
            smp_q  <= '0;
            prev_q <= '0;
        end else if (val_i) begin
            cnt_q  <= cnt_q + 1'b1;
            smp_q  <= dat_i;
            prev_q <= dat_i;
            if (state_q != S_IDLE && !word_ok) err_q <= 1'b1;
        end
    end

    assign err_o     = err_q;
    assign res_val_o = (state_q == S_CHECKING);
    assign cnt_o     = cnt_q;
    assign smp_o     = smp_q;

    // R1: disable clears every result
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!err_o && !res_val_o && cnt_o == '0 && smp_o == '0));
    // R5: no result before a seed word has been taken
    a_r5_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !res_val_o);
    a_r5_rise_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_val_o) |-> ($past(val_i) && $past(en_i)));
    // R6: sticky error
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && err_o) |=> err_o);
    // R7: one count per valid word
    a_r7_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && val_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
    // R9: idle cycles leave results untouched
    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !val_i) |=> ($stable(cnt_o) && $stable(smp_o) && $stable(err_o)));

endmodule

// File: rtl/seq_stream_checker.sv
module seq_stream_checker #(
    parameter int SEQ_W     = 32,
    parameter int DATA_W    = 64,
    parameter int NUM_STEPS = 4,
    parameter int CNT_W     = 32,
    parameter bit USE_STEPS = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       mode_sel,
    input  logic [NUM_STEPS*SEQ_W-1:0] step_vec,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          in_data,
    output logic                       seq_err,
    output logic                       res_valid,
    output logic [CNT_W-1:0]           rx_count,
    output logic [SEQ_W-1:0]           rx_sample
);

    logic             f_en, f_sel, f_val;
    logic [SEQ_W-1:0] f_dat;

    seqchk_fold #(
        .DATA_W (DATA_W),
        .SEQ_W  (SEQ_W)
    ) u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .sel_i  (mode_sel),
        .val_i  (in_valid),
        .data_i (in_data),
        .en_o   (f_en),
        .sel_o  (f_sel),
        .val_o  (f_val),
        .dat_o  (f_dat)
    );

    seqchk_core #(
        .SEQ_W     (SEQ_W),
        .NUM_STEPS (NUM_STEPS),
        .CNT_W     (CNT_W),
        .USE_STEPS (USE_STEPS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (f_en),
        .sel_i      (f_sel),
        .step_vec_i (step_vec),
        .val_i      (f_val),
        .dat_i      (f_dat),
        .err_o      (seq_err),
        .res_val_o  (res_valid),
        .cnt_o      (rx_count),
        .smp_o      (rx_sample)
    );

endmodule

// File: tb/test_seq_stream_checker.sv
module test_seq_stream_checker;

    localparam int SW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, sel = 1'b0, vld = 1'b0;
    logic [DW-1:0] din = '0;
    logic [4*SW-1:0] steps = {8'd5, 8'hFE, 8'd3, 8'd1};

    logic        a_err, a_rv, b_err, b_rv;
    logic [31:0] a_cnt, b_cnt;
    logic [7:0]  a_smp, b_smp;

    always #10 clk = ~clk;

    seq_stream_checker #(.SEQ_W(SW), .DATA_W(DW), .NUM_STEPS(4), .CNT_W(32), .USE_STEPS(1'b1)) i_seq_stream_checker (
        .clk(clk), .rst_n(rst_n), .enable(en), .mode_sel(sel), .step_vec(steps),
        .in_valid(vld), .in_data(din), .seq_err(a_err), .res_valid(a_rv),
        .rx_count(a_cnt), .rx_sample(a_smp));

    seq_stream_checker #(.SEQ_W(SW), .DATA_W(SW), .NUM_STEPS(4), .CNT_W(32), .USE_STEPS(1'b0)) i_seq_stream_checker_unit (
        .clk(clk), .rst_n(rst_n), .enable(en), .mode_sel(sel), .step_vec(steps),
        .in_valid(vld), .in_data(din[7:0]), .seq_err(b_err), .res_valid(b_rv),
        .rx_count(b_cnt), .rx_sample(b_smp));

    typedef struct packed {
        logic        e;
        logic        v;
        logic [31:0] c;
        logic [7:0]  s;
    } obs_t;

    obs_t qa[$];
    obs_t qb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    logic [1:0]  m_st[2];
    logic        m_err[2];
    logic [31:0] m_cnt[2];
    logic [7:0]  m_smp[2];
    logic [7:0]  m_prev[2];

    // R2 rule: shift left, feedback = xor of bits 7,5,4,3
    function automatic logic [7:0] ref_lfsr(input logic [7:0] p);
        return {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
    endfunction

    task automatic model(input int k, input logic e, input logic s, input logic v,
                         input logic [7:0] w, input bit stp);
        logic       ok;
        logic [7:0] t;
        if (!e) begin
            m_st[k] = 2'd0; m_err[k] = 1'b0; m_cnt[k] = 32'd0; m_smp[k] = 8'd0; m_prev[k] = 8'd0;
        end else if (v) begin
            m_cnt[k] = m_cnt[k] + 32'd1;
            m_smp[k] = w;
            if (m_st[k] != 2'd0) begin
                ok = 1'b0;
                if (s) begin
                    if (stp) begin
                        for (int i = 0; i < 4; i++) begin
                            t = m_prev[k] + steps[i*8 +: 8];
                            if (t == w) ok = 1'b1;
                        end
                    end else begin
                        t = m_prev[k] + 8'd1;
                        ok = (t == w);
                    end
                end else begin
                    ok = (ref_lfsr(m_prev[k]) == w);
                end
                if (!ok) m_err[k] = 1'b1;
                m_st[k] = 2'd2;
            end else begin
                m_st[k] = 2'd1;
            end
            m_prev[k] = w;
        end
    endtask

    task automatic drive(input logic e, input logic s, input logic v,
                         input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        en = e; sel = s; vld = v; din = {hi, lo};
        model(0, e, s, v, (hi == lo) ? lo : 8'hFF, 1'b1);
        model(1, e, s, v, lo, 1'b0);
        qa.push_back({m_err[0], m_st[0] == 2'd2, m_cnt[0], m_smp[0]});
        qb.push_back({m_err[1], m_st[1] == 2'd2, m_cnt[1], m_smp[1]});
    endtask

    task automatic word(input logic s, input logic [7:0] w);
        drive(1'b1, s, 1'b1, w, w);
    endtask

    task automatic gap(input logic s);
        drive(1'b1, s, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic off();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic compare(input string who, input obs_t exp, input obs_t act);
        n_chk++;
        if (exp != act) begin
            n_bad++;
            if (exp.e != act.e) $display("FAIL R6 %s seq_err act=%0b exp=%0b", who, act.e, exp.e);
            if (exp.v != act.v) $display("FAIL R5 %s res_valid act=%0b exp=%0b", who, act.v, exp.v);
            if (exp.c != act.c) $display("FAIL R7 %s rx_count act=%0d exp=%0d", who, act.c, exp.c);
            if (exp.s != act.s) $display("FAIL R8 %s rx_sample act=%02h exp=%02h", who, act.s, exp.s);
        end
    endtask

    // Monitor: folded instance lags two edges, unfolded one edge (R11)
    always @(posedge clk) begin : mon
        obs_t x;
        #5;
        if (qa.size() >= 2) begin
            x = qa.pop_front();
            compare("fold", x, {a_err, a_rv, a_cnt, a_smp});
        end
        if (qb.size() >= 1) begin
            x = qb.pop_front();
            compare("unit", x, {b_err, b_rv, b_cnt, b_smp});
        end
    end

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] p;
        for (int k = 0; k < 2; k++) begin
            m_st[k] = 0; m_err[k] = 0; m_cnt[k] = 0; m_smp[k] = 0; m_prev[k] = 0;
        end
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        compare("fold", '0, {a_err, a_rv, a_cnt, a_smp});
        compare("unit", '0, {b_err, b_rv, b_cnt, b_smp});
        @(negedge clk);
        rst_n = 1'b1;
        off(); off();

        // R3/R4/R9/R5: counter with steps +1,+3,-2,+5 and gaps; +1-only instance fails
        word(1, 8'd10); gap(1); word(1, 8'd11); word(1, 8'd14);
        gap(1); gap(1); word(1, 8'd12); word(1, 8'd17); gap(1);
        // R1: disable clears
        off(); off();

        // R2/R6: pseudo-random stream, one bad word, sticky afterwards
        p = 8'h5A;
        word(0, p);
        for (int i = 0; i < 4; i++) begin
            p = ref_lfsr(p);
            word(0, p);
        end
        p = ref_lfsr(p) ^ 8'h01;
        word(0, p);
        for (int i = 0; i < 3; i++) begin
            p = ref_lfsr(p);
            word(0, p);
            gap(0);
        end
        off();

        // R4: rollover from all ones to zero accepted
        word(1, 8'hFD); word(1, 8'hFE); word(1, 8'hFF); word(1, 8'h00); word(1, 8'h01);
        off();

        // R10: upper copy disagrees, folded word becomes all ones
        word(1, 8'h11); word(1, 8'h12);
        drive(1'b1, 1'b1, 1'b1, 8'h13, 8'h12);
        word(1, 8'h00);
        off();

        // R11: mode change while enabled applies to next word, error kept
        word(1, 8'h20); word(1, 8'h21);
        p = ref_lfsr(8'h21);
        word(0, p);
        word(1, p + 8'd1);
        word(1, p + 8'd9);
        p = ref_lfsr(p + 8'd9);
        word(0, p);
        p = ref_lfsr(p);
        word(0, p);
        off(); off(); off();
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule